// File: doc/BRIEF.md
# Serial Bit-Clock Selector and Recovery Loop

This block supplies the bit timing for one synchronous serial line. A two-bit mode input picks either direct external clocking, where the receive and transmit pins carry one-times bit clocks from the far end or a modem, or an internal recovery loop that runs from a source at sixteen times the bit rate. That source is either the receive-clock pin or the system clock. In the recovery modes the block tracks transitions on the receive data line to place a sample strobe near the middle of each bit. It also divides the source by sixteen and drives the result out on the transmit-clock pin, whose output enable follows the mode.

All logic runs on the system clock. The clock and data pins are synchronised with two flip-flop stages and their edges are detected in the system clock domain. A framing layer sits on both sides of the block. It supplies the next transmit bit and takes it when `tx_take` pulses. It takes a decoded receive bit whenever `rx_stb` pulses. Line coding is NRZ, or NRZI where a zero is sent as a level change and a one as no change.

Top module: `serclk_recov`

## Requirements
- R1: After reset `txc_pin_oe`, `rx_stb` and `tx_take` are 0 and `txd` is 1.
- R2: In mode 00, every rising edge seen on `rxc_pin` produces exactly one `rx_stb` pulse. The pulse carries the `rxd` level that was present at that edge.
- R3: In mode 00, every falling edge seen on `txc_pin_in` produces exactly one `tx_take` pulse. `txd` is updated from `tx_bit` in the same cycle.
- R4: `txc_pin_oe` is 1 in modes 01 and 10 and 0 otherwise. In those two modes `txc_pin_out` is the source divided by 16: high for 8 ticks and low for 8 ticks. Each of its falling edges coincides with a `tx_take` pulse.
- R5: In mode 10 the system clock is the 16x source. With no data transitions, `rx_stb` and `tx_take` each recur every 16 system clocks.
- R6: In mode 01 each rising edge of `rxc_pin` is one tick. With no data transitions, `rx_stb` and `tx_take` each recur every 16 periods of `rxc_pin`.
- R7: The loop counts 0 to 15 per bit and strobes at count 8. A data transition seen at count 8 to 15 holds count 15 one extra tick, so the next strobe interval is 17 ticks.
- R8: A data transition seen at count 0 to 7 makes the count jump from 14 to 0. The strobe after the next one therefore comes 15 ticks later.
- R9: With `nrzi_en` = 0, `rx_bit` equals the sampled line level and `txd` equals the accepted `tx_bit`.
- R10: With `nrzi_en` = 1, an accepted 0 inverts `txd` and an accepted 1 leaves it unchanged. `txd` starts at 1.
- R11: With `nrzi_en` = 1, `rx_bit` is 1 when the sampled level equals the previous sampled level and 0 otherwise. The previous level is 1 after reset.
- R12: Mode 11 behaves exactly as mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the 16x source in mode 10 |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | 00/11 external clocks, 01 recovery from RxC pin, 10 recovery from system clock |
| nrzi_en | input | 1 | 1 selects NRZI coding, 0 selects NRZ |
| rxc_pin | input | 1 | Receive clock pin: 1x clock in mode 00, 16x source in mode 01 |
| rxd | input | 1 | Serial receive data |
| txc_pin_in | input | 1 | Transmit clock pin, input side |
| tx_bit | input | 1 | Next data bit to send |
| txc_pin_out | output | 1 | Transmit clock pin, output side |
| txc_pin_oe | output | 1 | Output enable of the transmit clock pin |
| txd | output | 1 | Serial transmit data, line coded |
| tx_take | output | 1 | One-cycle pulse: `tx_bit` accepted |
| rx_stb | output | 1 | One-cycle pulse: `rx_bit` valid |
| rx_bit | output | 1 | Decoded receive bit |

## Verification
A bit counter that has slipped shows up as a wrong spacing between consecutive `rx_stb` pulses. The spacing is visible within one or two bit times of the disturbing data edge, so the bench stamps every strobe and compares the gaps to 15, 16 or 17 ticks. A wrong NRZI history register corrupts the very next decoded bit or transmitted level. Each table row therefore starts from reset and compares a whole byte in both directions. A divider fault appears in the duty cycle of `txc_pin_out` and in the spacing of `tx_take` within one period of 16 ticks.

// File: rtl/serclk_recov.sv
module serclk_recov #(
  parameter int OSR_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       nrzi_en,
  input  logic       rxc_pin,
  input  logic       rxd,
  input  logic       txc_pin_in,
  input  logic       tx_bit,
  output logic       txc_pin_out,
  output logic       txc_pin_oe,
  output logic       txd,
  output logic       tx_take,
  output logic       rx_stb,
  output logic       rx_bit
);
  localparam int OSR  = 1 << OSR_W;
  localparam logic [OSR_W-1:0] HALF = OSR_W'(OSR / 2);
  localparam logic [OSR_W-1:0] LAST = OSR_W'(OSR - 1);
  localparam logic [OSR_W-1:0] PENULT = OSR_W'(OSR - 2);
  localparam logic [1:0] M_PIN = 2'b01;
  localparam logic [1:0] M_SYS = 2'b10;
  localparam logic [1:0] ADJ_NONE = 2'd0, ADJ_SHORT = 2'd1, ADJ_LONG = 2'd2;

  logic rxd_m, rxd_s, rxc_m, rxc_s, rxc_d, txc_m, txc_s, txc_d;
  logic [OSR_W-1:0] cnt, tx_div;
  logic [1:0] adj, adj_eff;
  logic rxd_last, rx_prev;
  logic rec, tick, rx_smp, tx_adv, edge_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1; rxd_s <= 1'b1;
      rxc_m <= 1'b0; rxc_s <= 1'b0; rxc_d <= 1'b0;
      txc_m <= 1'b0; txc_s <= 1'b0; txc_d <= 1'b0;
    end else begin
      rxd_m <= rxd;        rxd_s <= rxd_m;
      rxc_m <= rxc_pin;    rxc_s <= rxc_m;    rxc_d <= rxc_s;
      txc_m <= txc_pin_in; txc_s <= txc_m;    txc_d <= txc_s;
    end
  end

  assign rec  = (mode == M_PIN) || (mode == M_SYS);
  assign tick = (mode == M_SYS) || ((mode == M_PIN) && rxc_s && !rxc_d);
  assign rx_smp = rec ? (tick && cnt == HALF) : (rxc_s && !rxc_d);
  assign tx_adv = rec ? (tick && tx_div == LAST) : (!txc_s && txc_d);
  assign edge_seen = rxd_s ^ rxd_last;
  assign adj_eff = edge_seen ? ((cnt < HALF) ? ADJ_SHORT : ADJ_LONG) : adj;
  assign txc_pin_oe  = rec;
  assign txc_pin_out = tx_div[OSR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; adj <= ADJ_NONE; rxd_last <= 1'b1; tx_div <= '0;
    end else if (tick) begin
      rxd_last <= rxd_s;
      tx_div   <= tx_div + 1'b1;
      if (cnt == PENULT && adj_eff == ADJ_SHORT) begin
        cnt <= '0; adj <= ADJ_NONE;
      end else if (cnt == LAST && adj_eff == ADJ_LONG) begin
        adj <= ADJ_NONE;
      end else begin
        cnt <= cnt + 1'b1; adj <= adj_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_stb <= 1'b0; rx_bit <= 1'b1; rx_prev <= 1'b1;
      tx_take <= 1'b0; txd <= 1'b1;
    end else begin
      rx_stb  <= rx_smp;
      tx_take <= tx_adv;
      if (rx_smp) begin
        rx_prev <= rxd_s;
        rx_bit  <= nrzi_en ? (rxd_s == rx_prev) : rxd_s;
      end
      if (tx_adv) txd <= nrzi_en ? (tx_bit ? txd : ~txd) : tx_bit;
    end
  end

  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb |=> !rx_stb);  // R2
  AST_TAKE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && rec && $past(rec)) |-> $fell(txc_pin_out));  // R4
  AST_NRZ_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !$past(nrzi_en)) |-> txd == $past(tx_bit));  // R9
  AST_NRZI_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && $past(nrzi_en)) |-> txd == ($past(tx_bit) ? $past(txd) : !$past(txd)));  // R10
  AST_NRZ_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && !$past(nrzi_en)) |-> rx_bit == $past(rxd_s));  // R9
  AST_EXT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec && $past(!rec)) |-> $stable(tx_div));  // R12
endmodule

// File: tb/serclk_recov_bench.sv
module serclk_recov_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b00;
  logic nrzi_en = 0, rxc_pin = 0, rxd = 1, txc_pin_in = 0, tx_bit = 1;
  logic txc_pin_out, txc_pin_oe, txd, tx_take, rx_stb, rx_bit;
  int n_chk = 0, n_fail = 0, cyc = 0, rx_n = 0, tx_n = 0;
  logic [7:0] rx_cap, tx_cap;
  bit done = 0;

  serclk_recov u_serclk_recov (.clk(clk), .rst_n(rst_n), .mode(mode), .nrzi_en(nrzi_en),
    .rxc_pin(rxc_pin), .rxd(rxd), .txc_pin_in(txc_pin_in), .tx_bit(tx_bit),
    .txc_pin_out(txc_pin_out), .txc_pin_oe(txc_pin_oe), .txd(txd), .tx_take(tx_take),
    .rx_stb(rx_stb), .rx_bit(rx_bit));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin rx_n = 0; tx_n = 0; rx_cap = '0; tx_cap = '0; end
    else begin
      if (rx_stb) begin if (rx_n < 8) rx_cap[rx_n] = rx_bit; rx_n++; end
      if (tx_take) begin if (tx_n < 8) tx_cap[tx_n] = txd; tx_n++; end
    end
  end

  // row: {mode, nrzi, line levels (bit0 first), data bits}
  localparam logic [18:0] VEC [6] = '{
    {2'b00, 1'b0, 8'hB2, 8'hB2},
    {2'b00, 1'b0, 8'h00, 8'h00},
    {2'b00, 1'b1, 8'hFF, 8'hFF},
    {2'b00, 1'b1, 8'hAA, 8'h00},
    {2'b11, 1'b1, 8'h0F, 8'hEF},
    {2'b11, 1'b0, 8'h5C, 8'h5C}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic wait_stb(output int t);
    do @(negedge clk); while (!rx_stb);
    t = cyc;
  endtask

  task automatic wait_take(output int t);
    do @(negedge clk); while (!tx_take);
    t = cyc;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3, t4, t5, a, b, hi;
    logic p;
    do_reset();
    chk(txc_pin_oe == 0, "R1 oe", txc_pin_oe, 0);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(rx_stb == 0 && tx_take == 0, "R1 strobes", {rx_stb, tx_take}, 0);

    foreach (VEC[r]) begin
      mode = VEC[r][18:17]; nrzi_en = VEC[r][16];
      rxd = 1; rxc_pin = 0; txc_pin_in = 0;
      do_reset();
      chk(txc_pin_oe == 0, "R4 R12 oe in external mode", txc_pin_oe, 0);
      for (int i = 0; i < 8; i++) begin
        rxd = VEC[r][8 + i];
        repeat (3) @(negedge clk); rxc_pin = 1;
        repeat (3) @(negedge clk); rxc_pin = 0;
        repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(rx_n == 8, "R2 R12 strobe count", rx_n, 8);
      chk(rx_cap == VEC[r][7:0], nrzi_en ? "R11 decode" : "R9 rx", rx_cap, VEC[r][7:0]);
      for (int i = 0; i < 8; i++) begin
        tx_bit = VEC[r][i];
        txc_pin_in = 1; repeat (3) @(negedge clk);
        txc_pin_in = 0; repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(tx_n == 8, "R3 take count", tx_n, 8);
      chk(tx_cap == VEC[r][15:8], nrzi_en ? "R10 encode" : "R9 tx", tx_cap, VEC[r][15:8]);
    end

    // recovery from system clock
    mode = 2'b10; nrzi_en = 0; rxd = 1; do_reset();
    chk(txc_pin_oe == 1, "R4 oe mode 10", txc_pin_oe, 1);
    wait_stb(t0); wait_stb(t1);
    chk(t1 - t0 == 16, "R5 strobe period", t1 - t0, 16);
    chk(rx_bit == 1, "R9 recovered bit", rx_bit, 1);
    rxd = 0;
    wait_stb(t2);
    chk(t2 - t1 == 17, "R7 lengthened bit", t2 - t1, 17);
    chk(rx_bit == 0, "R9 recovered bit after edge", rx_bit, 0);
    wait_stb(t3);
    chk(t3 - t2 == 16, "R7 back to nominal", t3 - t2, 16);
    repeat (8) @(negedge clk); rxd = 1;
    wait_stb(t4); wait_stb(t5);
    chk(t4 - t3 == 16, "R8 bit before shortening", t4 - t3, 16);
    chk(t5 - t4 == 15, "R8 shortened bit", t5 - t4, 15);
    chk(rx_bit == 1, "R9 recovered bit after short", rx_bit, 1);

    nrzi_en = 1; tx_bit = 0;
    wait_take(a); p = txd; hi = 0;
    forever begin
      @(negedge clk);
      if (tx_take) break;
      if (txc_pin_out) hi++;
    end
    b = cyc;
    chk(b - a == 16, "R5 take period", b - a, 16);
    chk(hi == 8, "R4 txc high ticks", hi, 8);
    chk(txd == !p, "R10 zero toggles", txd, !p);
    tx_bit = 1;
    wait_take(a); p = txd; wait_take(a);
    chk(txd == p, "R10 one holds", txd, p);

    // recovery from RxC pin
    mode = 2'b01; nrzi_en = 0; rxd = 1; do_reset();
    chk(txc_pin_oe == 1, "R4 oe mode 01", txc_pin_oe, 1);
    fork
      for (int k = 0; k < 120; k++) begin
        rxc_pin = 1; repeat (2) @(negedge clk);
        rxc_pin = 0; repeat (2) @(negedge clk);
      end
      begin
        wait_stb(t0); wait_stb(t1);
        wait_take(a); wait_take(b);
      end
    join
    chk(t1 - t0 == 64, "R6 strobe period", t1 - t0, 64);
    chk(b - a == 64, "R6 take period", b - a, 64);

    mode = 2'b11; @(negedge clk);
    chk(txc_pin_oe == 0, "R12 oe mode 11", txc_pin_oe, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule